// File: doc/BRIEF.md
# Single-Wire Bus Bit Slot Engine

This block produces the timed open-drain waveforms that a master on a single-wire bus uses to move one bit at a time. A controller asks for one slot by holding a request with a two-bit command code. The engine takes it only while idle. It drives an active-high pull-low enable for the slot's low interval and then releases the line to the external pull-up. Where the slot reads, it samples the bus input at a fixed point after release. When the slot's tail has elapsed it reports a single result bit with a one-cycle done pulse.

All intervals are whole microseconds. A prescaler built from the clocks-per-microsecond parameter turns the clock into microsecond steps. A runtime delay coefficient, latched when a command is accepted, multiplies every interval of that slot. A coefficient of zero is treated as one.

The command codes are:

| Code | Slot |
|------|------|
| 00 | write-0 |
| 01 | write-1 |
| 10 | read (the touch of a 1) |
| 11 | reset/presence |

Byte assembly, addressing commands, checksums and strong pull-up handling belong to the controller above this block.

Top module: `owb_slot_engine`

## Requirements
- R1: After reset, `busy`, `done`, `bus_pull_low` and `cmd_ack` are 0 and `result` is 1.
- R2: `cmd_ack` equals `cmd_req` while the engine is idle and is 0 while busy. A request made while busy is ignored: it changes neither the pull-low waveform nor the result.
- R3: Code 00 (write-0) pulls the line low for 60·K µs and then releases it for 10·K µs. Its result is 0.
- R4: Code 01 (write-1) pulls the line low for 6·K µs and then releases it for 64·K µs. Its result is 1.
- R5: Code 10 (read) pulls the line low for 6·K µs and releases it. It samples the synchronised bus 9·K µs after release and ends 55·K µs after the sample. Its result is the sampled level.
- R6: Code 11 (reset) pulls the line low for 500·K µs and samples the line 70·K µs after release. It then holds off for HOLDOFF_US·K µs (1000 µs by default) before done. Its result is 0 when a device pulled the line low (present) and 1 otherwise.
- R7: K is `delay_mult` as captured in the accept cycle, with 0 taken as 1. Changing `delay_mult` during a slot has no effect on that slot.
- R8: `busy` rises in the cycle after acceptance. `done` is a one-cycle pulse in the first cycle after `busy` falls. `result` changes only together with `done` and holds until the next one.
- R9: One µs is exactly CLKS_PER_US clock cycles. The pull-low enable rises in the cycle after the accept edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_req | input | 1 | Slot request |
| cmd_code | input | 2 | Slot type: 00 write-0, 01 write-1, 10 read, 11 reset |
| cmd_ack | output | 1 | Request accepted this cycle |
| delay_mult | input | MULT_W | Interval multiplier, 0 treated as 1 |
| busy | output | 1 | Slot in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 1 | Slot result bit, held between completions |
| bus_pull_low | output | 1 | Open-drain pull-low enable |
| bus_in | input | 1 | Sensed bus level (asynchronous) |

## Verification
Take C as CLKS_PER_US and K as the effective multiplier, and number clock edges from the accept edge as 0. The pull-low enable rises after edge 0 and falls after edge low·K·C. The sample is taken at edge (low+mid)·K·C. `busy` falls and `done` and `result` appear after edge (low+mid+tail)·K·C. A behavioural model in the bench advances on the same edges using these totals. Its expected `busy`, `done`, `result`, `bus_pull_low` and `cmd_ack` are compared with the design on every falling clock edge, half a cycle after each update. The bench holds the bus level constant across each slot, so the two-stage input synchroniser does not move the sampled value. Separate per-slot checks compare the counted pull-low cycles and the final result with the values each requirement fixes.

// File: rtl/owb_pkg.sv
package owb_pkg;

    typedef enum logic [1:0] {
        CMD_WR0 = 2'b00,
        CMD_WR1 = 2'b01,
        CMD_RD  = 2'b10,
        CMD_RST = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_LOW  = 2'b01,
        PH_MID  = 2'b10,
        PH_TAIL = 2'b11
    } phase_e;

    // interval lengths in microseconds (before scaling)
    localparam int unsigned W0_LOW_US   = 60;
    localparam int unsigned W0_MID_US   = 5;
    localparam int unsigned W0_TAIL_US  = 5;
    localparam int unsigned SH_LOW_US   = 6;
    localparam int unsigned SH_MID_US   = 9;
    localparam int unsigned SH_TAIL_US  = 55;
    localparam int unsigned RS_LOW_US   = 500;
    localparam int unsigned RS_MID_US   = 70;

    function automatic int unsigned longest_us(input int unsigned hold);
        return (hold > RS_LOW_US) ? hold : RS_LOW_US;
    endfunction

    function automatic logic [15:0] phase_us(input cmd_e c, input phase_e p,
                                             input int unsigned hold);
        int unsigned v;
        v = 0;
        case (p)
            PH_LOW:  v = (c == CMD_WR0) ? W0_LOW_US  : (c == CMD_RST) ? RS_LOW_US : SH_LOW_US;
            PH_MID:  v = (c == CMD_WR0) ? W0_MID_US  : (c == CMD_RST) ? RS_MID_US : SH_MID_US;
            PH_TAIL: v = (c == CMD_WR0) ? W0_TAIL_US : (c == CMD_RST) ? hold      : SH_TAIL_US;
            default: v = 0;
        endcase
        return v[15:0];
    endfunction

    function automatic logic slot_result(input cmd_e c, input logic sampled);
        case (c)
            CMD_WR0: return 1'b0;
            CMD_WR1: return 1'b1;
            default: return sampled;
        endcase
    endfunction

endpackage

// File: rtl/owb_sync.sv
module owb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_one
            logic r;
            always_ff @(posedge clk) begin
                if (rst) r <= 1'b1;
                else     r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= {sh[STAGES-2:0], d};
            end
            assign q = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/owb_interval_timer.sv
module owb_interval_timer #(
    parameter int CLKS_PER_US = 200,
    parameter int US_W        = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [US_W-1:0] load_us,
    output logic            expire
);
    localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);

    logic [PRE_W-1:0] pre;
    logic [US_W-1:0]  left;
    logic             step;

    assign step   = (pre == PRE_LAST);
    assign expire = step && (left == US_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pre  <= '0;
            left <= '0;
        end else if (load) begin
            pre  <= '0;
            left <= load_us;
        end else if (left != '0) begin
            if (step) begin
                pre  <= '0;
                left <= left - US_W'(1);
            end else begin
                pre <= pre + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/owb_slot_engine.sv
module owb_slot_engine
    import owb_pkg::*;
#(
    parameter int CLKS_PER_US = 200,
    parameter int HOLDOFF_US  = 1000,
    parameter int MULT_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_req,
    input  logic [1:0]        cmd_code,
    output logic              cmd_ack,
    input  logic [MULT_W-1:0] delay_mult,
    output logic              busy,
    output logic              done,
    output logic              result,
    output logic              bus_pull_low,
    input  logic              bus_in
);
    localparam int unsigned MAX_US = longest_us(HOLDOFF_US);
    localparam int US_W = $clog2(MAX_US * ((1 << MULT_W) - 1) + 1);

    phase_e            state, nxt_phase;
    cmd_e              cur_cmd, nxt_cmd;
    logic [MULT_W-1:0] cur_mult, nxt_mult, eff_mult;
    logic              sampled;
    logic              bus_s;
    logic              accept;
    logic              expire;
    logic              load;
    logic [US_W-1:0]   load_us;

    owb_sync #(.STAGES(2)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (bus_in),
        .q   (bus_s)
    );

    owb_interval_timer #(.CLKS_PER_US(CLKS_PER_US), .US_W(US_W)) tmr_i (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .load_us (load_us),
        .expire  (expire)
    );

    assign accept   = cmd_req && (state == PH_IDLE);
    assign eff_mult = (delay_mult == '0) ? MULT_W'(1) : delay_mult;

    always_comb begin
        nxt_cmd  = accept ? cmd_e'(cmd_code) : cur_cmd;
        nxt_mult = accept ? eff_mult : cur_mult;
        case (state)
            PH_IDLE: nxt_phase = PH_LOW;
            PH_LOW:  nxt_phase = PH_MID;
            PH_MID:  nxt_phase = PH_TAIL;
            default: nxt_phase = PH_IDLE;
        endcase
        load    = accept || (expire && (state == PH_LOW || state == PH_MID));
        load_us = US_W'(phase_us(nxt_cmd, nxt_phase, HOLDOFF_US)) * US_W'(nxt_mult);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PH_IDLE;
            cur_cmd  <= CMD_WR0;
            cur_mult <= MULT_W'(1);
            sampled  <= 1'b1;
            done     <= 1'b0;
            result   <= 1'b1;
        end else begin
            done <= 1'b0;
            if (accept) begin
                state    <= PH_LOW;
                cur_cmd  <= nxt_cmd;
                cur_mult <= nxt_mult;
            end else if (expire) begin
                case (state)
                    PH_LOW: state <= PH_MID;
                    PH_MID: begin
                        state   <= PH_TAIL;
                        sampled <= bus_s;
                    end
                    PH_TAIL: begin
                        state  <= PH_IDLE;
                        done   <= 1'b1;
                        result <= slot_result(cur_cmd, sampled);
                    end
                    default: state <= PH_IDLE;
                endcase
            end
        end
    end

    assign cmd_ack      = accept;
    assign busy         = (state != PH_IDLE);
    assign bus_pull_low = (state == PH_LOW);
endmodule

// File: rtl/owb_slot_chk.sv
module owb_slot_chk (
    input logic clk,
    input logic rst,
    input logic cmd_ack,
    input logic busy,
    input logic done,
    input logic result,
    input logic bus_pull_low
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R9
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_ack |=> (busy && bus_pull_low));

    // R2
    rise_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_pull_low) |-> $past(cmd_ack));

    // R3
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_pull_low);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));
endmodule

bind owb_slot_engine owb_slot_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .cmd_ack      (cmd_ack),
    .busy         (busy),
    .done         (done),
    .result       (result),
    .bus_pull_low (bus_pull_low)
);

// File: tb/owb_slot_engine_tb.sv
`timescale 1ns/1ps
module owb_slot_engine_tb_top;
    localparam int CPU    = 2;
    localparam int HOLD   = 1000;
    localparam int MULT_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_req = 1'b0;
    logic [1:0]        cmd_code = 2'b00;
    logic [MULT_W-1:0] delay_mult = 8'd1;
    logic              bus_in = 1'b1;
    logic              cmd_ack, busy, done, result, bus_pull_low;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int low_cnt = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    owb_slot_engine #(.CLKS_PER_US(CPU), .HOLDOFF_US(HOLD), .MULT_W(MULT_W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .cmd_req      (cmd_req),
        .cmd_code     (cmd_code),
        .cmd_ack      (cmd_ack),
        .delay_mult   (delay_mult),
        .busy         (busy),
        .done         (done),
        .result       (result),
        .bus_pull_low (bus_pull_low),
        .bus_in       (bus_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic string cmd_tag(input int c);
        case (c)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // behavioural reference model
    bit m_busy = 0, m_done = 0, m_pl = 0, m_res = 1, m_samp = 1;
    int m_t = 0, m_low = 0, m_mid = 0, m_tot = 0, m_cmd = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_pl = 0; m_res = 1; m_t = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_t++;
                if (m_t == m_low) m_pl = 0;
                if (m_t == m_low + m_mid) m_samp = bus_in;
                if (m_t == m_tot) begin
                    m_busy = 0;
                    m_done = 1;
                    m_res = (m_cmd == 0) ? 1'b0 : (m_cmd == 1) ? 1'b1 : m_samp;
                end
            end else if (cmd_req) begin
                int k;
                int l, md, tl;
                k = (delay_mult == 0) ? 1 : int'(delay_mult);
                m_cmd = int'(cmd_code);
                case (m_cmd)
                    0: begin l = 60;  md = 5;  tl = 5;    end
                    3: begin l = 500; md = 70; tl = HOLD; end
                    default: begin l = 6; md = 9; tl = 55; end
                endcase
                m_low = l * k * CPU;
                m_mid = md * k * CPU;
                m_tot = (l + md + tl) * k * CPU;
                m_busy = 1; m_pl = 1; m_t = 0;
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (bus_pull_low) low_cnt++;
        if (started && !rst) begin
            chk(busy == m_busy, "R8 busy", busy, m_busy);
            chk(done == m_done, "R8 done", done, m_done);
            chk(bus_pull_low == m_pl, {cmd_tag(m_cmd), " pull_low"}, bus_pull_low, m_pl);
            chk(result == m_res, {cmd_tag(m_cmd), " result"}, result, m_res);
            chk(cmd_ack == (cmd_req && !m_busy), "R2 ack", cmd_ack, cmd_req && !m_busy);
        end
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // one slot; chg_mult>=0 rewrites delay_mult mid-slot; intr pulses a request while busy
    task automatic do_slot(input int code, input int mult, input bit lvl,
                           input int exp_res, input int exp_low, input string tag,
                           input int chg_mult, input bit intr);
        @(negedge clk);
        cmd_req = 1; cmd_code = 2'(code); delay_mult = MULT_W'(mult); bus_in = lvl;
        low_cnt = 0;
        @(negedge clk);
        cmd_req = 0;
        if (chg_mult >= 0) delay_mult = MULT_W'(chg_mult);
        if (intr) begin
            repeat (3) @(negedge clk);
            cmd_req = 1; cmd_code = 2'b11;
            repeat (3) @(negedge clk);
            cmd_req = 0;
        end
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        chk(done == 1'b1, {tag, " done seen"}, done, 1);
        chk(result == exp_res[0], {tag, " result"}, result, exp_res);
        chk(low_cnt == exp_low, {tag, " low cycles"}, low_cnt, exp_low);
        bus_in = 1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(busy == 0, "R1 busy", busy, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(bus_pull_low == 0, "R1 pull_low", bus_pull_low, 0);
        chk(result == 1, "R1 result", result, 1);
        chk(cmd_ack == 0, "R1 ack", cmd_ack, 0);
        rst = 0;
        started = 1;
        @(negedge clk);
        chk(busy == 0 && result == 1, "R1 after release", busy, 0);

        do_slot(0, 1, 1, 0, 60*CPU,  "R3 write0", -1, 0);
        do_slot(1, 1, 0, 1, 6*CPU,   "R4 write1", -1, 0);
        do_slot(2, 1, 0, 0, 6*CPU,   "R5 read low", -1, 0);
        do_slot(2, 1, 1, 1, 6*CPU,   "R5 read high", -1, 0);
        do_slot(3, 1, 0, 0, 500*CPU, "R6 reset present", -1, 0);
        do_slot(3, 1, 1, 1, 500*CPU, "R6 reset absent", -1, 0);
        do_slot(0, 3, 1, 0, 180*CPU, "R7 mult3 write0", -1, 0);
        do_slot(2, 0, 0, 0, 6*CPU,   "R7 mult0 read", -1, 0);
        do_slot(1, 2, 1, 1, 12*CPU,  "R7 mult change mid-slot", 5, 0);
        do_slot(0, 1, 1, 0, 60*CPU,  "R2 request while busy", -1, 1);
        do_slot(2, 4, 1, 1, 24*CPU,  "R9 read mult4", -1, 0);

        // R2: request held across done is taken in the first idle cycle
        @(negedge clk);
        cmd_req = 1; cmd_code = 2'b01; delay_mult = 8'd1; low_cnt = 0;
        @(negedge clk);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        chk(done == 1, "R2 back-to-back done", done, 1);
        chk(cmd_ack == 1, "R2 back-to-back ack", cmd_ack, 1);
        @(negedge clk);
        cmd_req = 0;
        chk(busy == 1 && bus_pull_low == 1, "R9 pull low after accept", bus_pull_low, 1);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        chk(result == 1, "R4 second write1 result", result, 1);
        repeat (3) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule